// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block holds the control logic of a trimmer with one hundred taps. A host drives three pins: an active-low select, an increment strobe and a direction level. While the block is selected, each falling edge of the strobe moves a seven-bit tap position one step. The step goes up when the direction is high and down when it is low. The position stops at the two ends of the range and never wraps. The position is decoded into a one-hot vector with one bit per tap, which drives the switch network of the resistor ladder.

Raising select ends a selection. The level of the strobe at that moment sets what happens. A high strobe commits the live position to a non-volatile register kept inside the block. That write keeps the block busy for a set number of clock cycles. A low strobe ends the selection without a write, and the live position stays in place. Reset stands in for a power cycle: during reset the position is reloaded from the non-volatile register, and that register keeps its contents through reset. All three host pins are brought into the clock domain through two-flop synchronisers, and their edges are found in that domain.

Top module: `tap_trim_ctrl`

## Requirements
- R1: While rst_n is low and after it returns high, tap_pos_o equals the value last committed to the non-volatile register (NV_INIT when nothing has been committed since start-up). After reset, store_busy_o is 0 and standby_o is 1.
- R2: While select is low, a high-to-low transition of inc_i moves tap_pos_o by one step. The direction is the value dir_up_i had at that falling edge: 1 steps up and 0 steps down. A change of dir_up_i while inc_i stays low does not move the wiper. The direction may change between steps within one selection.
- R3: tap_pos_o never exceeds NUM_TAPS-1. A step up at NUM_TAPS-1 leaves it unchanged, and so does a step down at 0.
- R4: Transitions of inc_i while sel_n_i is high leave tap_pos_o unchanged.
- R5: A rising edge of sel_n_i while inc_i is high starts a commit. store_busy_o is then high for exactly STORE_CYCLES clock cycles, and the next reset recalls the committed position.
- R6: A rising edge of sel_n_i while inc_i is low commits nothing. store_busy_o stays 0, tap_pos_o keeps its value, and the next reset recalls the earlier committed value.
- R7: While store_busy_o is high, falling edges of inc_i do not move tap_pos_o, and a further commit request is dropped.
- R8: tap_sel_o has exactly one bit set, at bit index tap_pos_o.
- R9: standby_o is high exactly when the synchronised select is high and no commit is in progress. It is low two cycles after sel_n_i has been held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; recalls the committed position |
| sel_n_i | input | 1 | Host select, active low, asynchronous |
| inc_i | input | 1 | Host step strobe; the falling edge moves the wiper |
| dir_up_i | input | 1 | Host direction: 1 steps up, 0 steps down |
| tap_pos_o | output | 7 | Current tap index, 0 to NUM_TAPS-1 |
| tap_sel_o | output | 100 | One-hot tap select, bit i set for position i |
| store_busy_o | output | 1 | Commit to the non-volatile register in progress |
| standby_o | output | 1 | Deselected and idle |

## Verification
The bench pushes the wiper past both ends. A counter that wraps would jump from 99 to 0, or from 0 to 99, and a counter that is off by one at the limits would reach 100 or underflow. It changes direction while the strobe is held low. A design that samples direction on the rising edge, or moves on both edges, would end one step off. It checks the commit choice from both strobe levels and reads the stored value back through a reset. A design that stores on every deselect, or never stores, recalls the wrong tap. It strobes during a commit and times the busy window, which catches a wiper that still moves while busy and a busy flag one cycle long or short.

// File: rtl/trim_pkg.sv
// Package: shared types for the tap trim controller.
// Assumes: host pins arrive asynchronous and are synchronised before use.
package trim_pkg;

    // Synchronised view of the three host pins
    typedef struct packed {
        logic sel_n;
        logic inc;
        logic dir_up;
    } host_pins_t;

    // Idle levels of the host pins: deselected, strobe high
    localparam host_pins_t HOST_IDLE = '{sel_n: 1'b1, inc: 1'b1, dir_up: 1'b0};

endpackage

// File: rtl/trim_input_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous pins.
// What it does: passes each bit through STAGES flops in the clk domain.
// Assumes: each bit is independent; reset loads RESET_VAL into every stage.
module trim_input_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= RESET_VAL;
                    else        chain_q[s] <= async_i;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= RESET_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/trim_tap_counter.sv
// Module: saturating up/down tap counter.
// What it does: steps by one on step_en, clamps at 0 and NUM_TAPS-1, loads
// recall_val during reset.
// Assumes: recall_val is already within range.
module trim_tap_counter #(
    parameter int NUM_TAPS = 100,
    parameter int CNT_W    = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] recall_val,
    input  logic             step_en,
    input  logic             step_up,
    output logic [CNT_W-1:0] pos_o
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(NUM_TAPS - 1);

    logic [CNT_W-1:0] pos_q;

    // Recall on reset, otherwise a single clamped step when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= recall_val;
        end else if (step_en) begin
            if (step_up && pos_q != TOP)
                pos_q <= pos_q + 1'b1;
            else if (!step_up && pos_q != '0)
                pos_q <= pos_q - 1'b1;
        end
    end

    assign pos_o = pos_q;

endmodule

// File: rtl/trim_store_ctrl.sv
// Module: commit sequencer and behavioural non-volatile register.
// What it does: on an accepted request, captures data and holds busy for
// STORE_CYCLES cycles, then writes the non-volatile register.
// Assumes: the non-volatile register keeps its contents through rst_n;
// its start-up content is NV_INIT. A reset during a commit aborts it.
module trim_store_ctrl #(
    parameter int CNT_W        = 7,
    parameter int STORE_CYCLES = 1_000_000,
    parameter int NV_INIT      = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] data_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] nv_o
);

    localparam int BUSY_W = $clog2(STORE_CYCLES + 1);
    localparam logic [BUSY_W-1:0] LOAD = BUSY_W'(STORE_CYCLES);

    logic [BUSY_W-1:0] busy_cnt_q;
    logic [CNT_W-1:0]  pending_q;
    logic [CNT_W-1:0]  nv_q = CNT_W'(NV_INIT);
    logic              idle;

    assign idle = (busy_cnt_q == '0);

    // Write-busy timer: loads on an accepted request, counts to zero
    always_ff @(posedge clk) begin
        if (!rst_n)            busy_cnt_q <= '0;
        else if (idle && req_i) busy_cnt_q <= LOAD;
        else if (!idle)        busy_cnt_q <= busy_cnt_q - 1'b1;
    end

    // Capture of the value to be committed
    always_ff @(posedge clk) begin
        if (idle && req_i) pending_q <= data_i;
    end

    // Non-volatile cell model: written on the last busy cycle, never reset
    always_ff @(posedge clk) begin
        if (rst_n && busy_cnt_q == BUSY_W'(1)) nv_q <= pending_q;
    end

    assign busy_o = !idle;
    assign nv_o   = nv_q;

endmodule

// File: rtl/trim_tap_decoder.sv
// Module: binary to one-hot tap decoder.
// What it does: raises bit i of sel_o when pos_i equals i.
// Assumes: pos_i stays below NUM_TAPS.
module trim_tap_decoder #(
    parameter int NUM_TAPS = 100,
    parameter int CNT_W    = $clog2(NUM_TAPS)
) (
    input  logic [CNT_W-1:0]    pos_i,
    output logic [NUM_TAPS-1:0] sel_o
);

    genvar i;
    generate
        for (i = 0; i < NUM_TAPS; i++) begin : g_tap
            assign sel_o[i] = (pos_i == CNT_W'(i));
        end
    endgenerate

endmodule

// File: rtl/tap_trim_ctrl.sv
// Module: top of the wiper position controller.
// What it does: synchronises the host pins, finds strobe and select edges,
// steps a saturating tap counter, decodes it to one-hot, and commits the
// position on a deselect with the strobe high.
// Assumes: host pulses last longer than three clock cycles.
module tap_trim_ctrl #(
    parameter int NUM_TAPS     = 100,
    parameter int STORE_CYCLES = 1_000_000,
    parameter int NV_INIT      = 0,
    parameter int SYNC_STAGES  = 2,
    parameter int CNT_W        = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n_i,
    input  logic                inc_i,
    input  logic                dir_up_i,
    output logic [CNT_W-1:0]    tap_pos_o,
    output logic [NUM_TAPS-1:0] tap_sel_o,
    output logic                store_busy_o,
    output logic                standby_o
);

    import trim_pkg::*;

    host_pins_t       pins_s;
    logic             sel_prev_q;
    logic             inc_prev_q;
    logic             inc_fall;
    logic             desel_rise;
    logic             step_en;
    logic             store_req;
    logic [CNT_W-1:0] nv_val;

    trim_input_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (HOST_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_n_i, inc_i, dir_up_i}),
        .sync_o  (pins_s)
    );

    // Previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev_q <= HOST_IDLE.sel_n;
            inc_prev_q <= HOST_IDLE.inc;
        end else begin
            sel_prev_q <= pins_s.sel_n;
            inc_prev_q <= pins_s.inc;
        end
    end

    // Edge qualification and gating by the commit timer
    always_comb begin
        inc_fall   = inc_prev_q && !pins_s.inc && !pins_s.sel_n;
        desel_rise = !sel_prev_q && pins_s.sel_n;
        step_en    = inc_fall && !store_busy_o;
        store_req  = desel_rise && pins_s.inc && !store_busy_o;
    end

    trim_tap_counter #(
        .NUM_TAPS (NUM_TAPS),
        .CNT_W    (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_val (nv_val),
        .step_en    (step_en),
        .step_up    (pins_s.dir_up),
        .pos_o      (tap_pos_o)
    );

    trim_store_ctrl #(
        .CNT_W        (CNT_W),
        .STORE_CYCLES (STORE_CYCLES),
        .NV_INIT      (NV_INIT)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (store_req),
        .data_i (tap_pos_o),
        .busy_o (store_busy_o),
        .nv_o   (nv_val)
    );

    trim_tap_decoder #(
        .NUM_TAPS (NUM_TAPS),
        .CNT_W    (CNT_W)
    ) u_decoder (
        .pos_i (tap_pos_o),
        .sel_o (tap_sel_o)
    );

    assign standby_o = pins_s.sel_n && !store_busy_o;

endmodule

// File: rtl/tap_trim_ctrl_checker.sv
// Module: property checker for tap_trim_ctrl, attached by bind.
// Assumes: observes only top-level pins.
module tap_trim_ctrl_checker #(
    parameter int NUM_TAPS = 100,
    parameter int CNT_W    = $clog2(NUM_TAPS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel_n_i,
    input logic [CNT_W-1:0]    tap_pos_o,
    input logic [NUM_TAPS-1:0] tap_sel_o,
    input logic                store_busy_o,
    input logic                standby_o
);

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tap_sel_o) == 1 && tap_sel_o[tap_pos_o]);  // R8

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tap_pos_o) < NUM_TAPS);  // R3

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (int'(tap_pos_o) == int'($past(tap_pos_o)) ||
                          int'(tap_pos_o) == int'($past(tap_pos_o)) + 1 ||
                          int'(tap_pos_o) + 1 == int'($past(tap_pos_o))));  // R2

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(store_busy_o)) |-> $stable(tap_pos_o));  // R7

    AST_SELECTED_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(sel_n_i, 2)) |-> !standby_o);  // R9

endmodule

bind tap_trim_ctrl tap_trim_ctrl_checker #(
    .NUM_TAPS (NUM_TAPS),
    .CNT_W    (CNT_W)
) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_n_i      (sel_n_i),
    .tap_pos_o    (tap_pos_o),
    .tap_sel_o    (tap_sel_o),
    .store_busy_o (store_busy_o),
    .standby_o    (standby_o)
);

// File: tb/tap_trim_ctrl_bench.sv
module tap_trim_ctrl_bench;

    localparam int NUM_TAPS = 100;
    localparam int STORE_CYC = 200;
    localparam int NV_START = 50;
    localparam int SETTLE = 5;

    // Vector: {dir[15], steps[14:7], expected position[6:0]}, walked in one selection
    localparam int NVEC = 7;
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 8'd3,   7'd53},
        {1'b0, 8'd5,   7'd48},
        {1'b1, 8'd60,  7'd99},
        {1'b1, 8'd2,   7'd99},
        {1'b0, 8'd120, 7'd0},
        {1'b0, 8'd1,   7'd0},
        {1'b1, 8'd10,  7'd10}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sel_n = 1'b1;
    logic                inc = 1'b1;
    logic                dir = 1'b0;
    logic [6:0]          pos;
    logic [NUM_TAPS-1:0] tsel;
    logic                busy;
    logic                stby;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tap_trim_ctrl #(
        .NUM_TAPS     (NUM_TAPS),
        .STORE_CYCLES (STORE_CYC),
        .NV_INIT      (NV_START)
    ) u_tap_trim_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_n_i      (sel_n),
        .inc_i        (inc),
        .dir_up_i     (dir),
        .tap_pos_o    (pos),
        .tap_sel_o    (tsel),
        .store_busy_o (busy),
        .standby_o    (stby)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step(input logic up);
        dir = up;  settle(SETTLE);
        inc = 1'b0; settle(SETTLE);
        inc = 1'b1; settle(SETTLE);
    endtask

    task automatic power_cycle();
        sel_n = 1'b1; inc = 1'b1; settle(SETTLE);
        rst_n = 1'b0; settle(4);
        rst_n = 1'b1; settle(SETTLE);
    endtask

    task automatic check_decode(input string tag, input int exp);
        chk(tag, $countones(tsel), 1);
        chk(tag, int'(tsel[exp]), 1);
    endtask

    initial begin
        int hi;
        settle(5);
        rst_n = 1'b1;
        settle(SETTLE);

        // R1 reset state recalls the start-up content
        chk("R1 pos after reset", int'(pos), NV_START);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R9 standby after reset", int'(stby), 1);
        check_decode("R8 decode after reset", NV_START);

        // R4 strobes while deselected are ignored
        step(1'b1); step(1'b0); step(1'b1);
        chk("R4 pos after deselected strobes", int'(pos), NV_START);

        // Select, then walk the vector table inside one selection
        sel_n = 1'b0; settle(SETTLE);
        chk("R9 standby while selected", int'(stby), 0);
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < int'(VEC[v][14:7]); k++) step(VEC[v][15]);
            chk("R2/R3 table position", int'(pos), int'(VEC[v][6:0]));
            check_decode("R8 table decode", int'(VEC[v][6:0]));
        end

        // R2 direction is taken at the falling edge only
        dir = 1'b1; settle(SETTLE);
        inc = 1'b0; settle(SETTLE);
        dir = 1'b0; settle(SETTLE);
        inc = 1'b1; settle(SETTLE);
        chk("R2 direction sampled at fall", int'(pos), 11);

        // R6 deselect with strobe low: final step counts, no commit
        inc = 1'b0; settle(SETTLE);
        chk("R2 down step before deselect", int'(pos), 10);
        sel_n = 1'b1; settle(SETTLE);
        chk("R6 no busy on plain deselect", int'(busy), 0);
        chk("R6 position kept", int'(pos), 10);
        chk("R9 standby after plain deselect", int'(stby), 1);
        inc = 1'b1; settle(SETTLE);
        chk("R4 strobe rise while deselected", int'(pos), 10);
        power_cycle();
        chk("R6 recall unchanged", int'(pos), NV_START);

        // R5 commit with strobe high
        sel_n = 1'b0; settle(SETTLE);
        for (int k = 0; k < 27; k++) step(1'b1);
        chk("R2 move to 77", int'(pos), 77);
        sel_n = 1'b1; settle(SETTLE);
        chk("R5 busy after commit", int'(busy), 1);
        chk("R9 standby low while busy", int'(stby), 0);

        // R7 strobes during the busy window are ignored, second request dropped
        sel_n = 1'b0; settle(SETTLE);
        step(1'b1); step(1'b0); step(1'b0);
        chk("R7 pos frozen while busy", int'(pos), 77);
        sel_n = 1'b1; settle(SETTLE);
        chk("R7 still busy", int'(busy), 1);
        hi = 0;
        while (busy && hi < 1000) begin hi++; @(negedge clk); end
        chk("R5 busy ends", int'(busy), 0);
        chk("R9 standby after commit", int'(stby), 1);
        power_cycle();
        chk("R5 recall committed", int'(pos), 77);

        // R5 busy window length and a second commit
        sel_n = 1'b0; settle(SETTLE);
        step(1'b0);
        chk("R2 step down to 76", int'(pos), 76);
        sel_n = 1'b1;
        hi = 0;
        while (!busy && hi < 20) begin hi++; @(negedge clk); end
        hi = 0;
        while (busy && hi < 1000) begin hi++; @(negedge clk); end
        chk("R5 busy length", hi, STORE_CYC);
        power_cycle();
        chk("R5 recall second commit", int'(pos), 76);
        check_decode("R8 decode after recall", 76);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule